// File: doc/BRIEF.md
# Power-on and Warm Reset Sequencer

This block sequences reset for a small device built from programmable memory and logic. It watches an active-low reset pin, a supply-good flag, a below-lockout flag and a power-down request. From these it decides whether a reset is a cold start or a warm restart, and whether the low pulse on the pin lasted long enough to count. A cold start must hold the pin low far longer than a warm restart. A pulse that is too short for the current mode is dropped and leaves no trace.

Once a reset qualifies, the block sends one-cycle strobes to the register classes:
- The page-mapping registers and the macrocell flip-flops are cleared only on a cold start.
- The general registers are cleared on both kinds of reset.
- The memory-mapping control register is loaded on both kinds of reset, with its configured default and with the status and peripheral bits forced to zero.

If a flash program or erase cycle is running at that moment, the block raises an abort request to the flash state machine for a fixed window. While the device is in reset, a single reset-mode output puts the MCU I/O into input mode and tri-states the address, data and peripheral ports. After the pin is released, a recovery window runs before the ready output rises. Flash write starts are blocked whenever the device is not ready or the supply is below lockout. Every time window is given in nanoseconds and converted to clock cycles, rounded up.

Top module: `rst_seq_mgr`

## Requirements
- R1: While supply_good is low, the block is held in its power-up state: in_reset is 1, ready is 0, and no strobe or abort is asserted.
- R2: After supply_good rises, a reset is accepted only if the synchronised pin stays low for at least POR_CYC = ceil(CLK_HZ*POR_NS/1e9) consecutive cycles (20000 by default). A shorter low pulse produces no strobe and leaves ready at 0.
- R3: While ready is 1, a low pulse of at least WARM_CYC = ceil(CLK_HZ*WARM_NS/1e9) cycles (3 by default) is accepted as a warm reset. A shorter pulse produces no strobe and ready stays 1 throughout.
- R4: Every accepted reset gives exactly one single-cycle pulse on gen_clr and one on vm_load. vm_init always equals VM_DEFAULT with the bits set in VM_ZERO_MASK cleared (8'hA0 by default).
- R5: pmmr_clr and mcell_clr pulse once, together with gen_clr, for the first accepted reset after power-up. They never pulse for a warm reset.
- R6: in_reset is 1 from the moment a reset is accepted until ready rises. With no abort pending, ready rises at the (REC_CYC+3)-th rising clock edge after the pin returns high (6 by default). This is two edges of synchroniser, one edge to leave the held state, and REC_CYC cycles of recovery.
- R7: If the pin goes low during the recovery window, the window restarts from zero once the pin is high again. A one-cycle dip that starts one edge after release delays ready to edge REC_CYC+5.
- R8: If flash_busy is 1 when a reset is accepted, flash_abort is 1 for exactly ABORT_CYC cycles (500 by default), and ready stays 0 until it ends. With flash_busy at 0, flash_abort stays 0.
- R9: wr_go equals wr_req only while ready is 1 and supply_low is 0. Otherwise wr_go is 0.
- R10: pd_mode is 1 while pd_req is 1 and ready is 1. A power-down request raises no strobe and leaves ready unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| supply_good | input | 1 | Supply stable; low acts as asynchronous power-up reset |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| supply_low | input | 1 | Supply below write lockout threshold |
| pd_req | input | 1 | Power-down request |
| flash_busy | input | 1 | Flash program or erase cycle in progress |
| wr_req | input | 1 | Request to start a flash write cycle |
| ready | output | 1 | Device operational, memory access allowed |
| in_reset | output | 1 | Reset mode: MCU I/O set to input, address, data and peripheral ports tri-stated |
| pmmr_clr | output | 1 | Clear strobe for the page-mapping registers (cold only) |
| mcell_clr | output | 1 | Clear strobe for the macrocell flip-flops (cold only) |
| gen_clr | output | 1 | Clear strobe for all other general registers |
| vm_load | output | 1 | Load strobe for the memory-mapping control register |
| vm_init | output | VM_W | Value to load into the memory-mapping control register |
| flash_abort | output | 1 | Abort request to the flash state machine, return to read mode |
| wr_go | output | 1 | Gated flash write start |
| pd_mode | output | 1 | Power-down mode active |

## Verification
The assertions assume the following about the inputs:
- The pin, when seen through the two-flop synchroniser, is a clean level.
- supply_good drops only as a real power loss, which resets every check.

The assertion that ready rises only out of recovery, and the assertion that abort excludes ready, both rely on flash_busy being sampled only at the moment a reset is accepted. The bench therefore changes every input on the falling clock edge and never glitches the pin within a cycle. It raises flash_busy only around the pulse it means to abort, and it keeps supply_good high from power-up onward.

// File: rtl/rst_seq_mgr.sv
module rst_seq_mgr #(
  parameter longint CLK_HZ       = 20_000_000,
  parameter longint POR_NS       = 1_000_000,
  parameter longint WARM_NS      = 150,
  parameter longint REC_NS       = 120,
  parameter longint ABORT_NS     = 25_000,
  parameter int     VM_W         = 8,
  parameter logic [VM_W-1:0] VM_DEFAULT   = 8'hA5,
  parameter logic [VM_W-1:0] VM_ZERO_MASK = 8'h0F
) (
  input  logic            clk,
  input  logic            supply_good,
  input  logic            rst_pin_n,
  input  logic            supply_low,
  input  logic            pd_req,
  input  logic            flash_busy,
  input  logic            wr_req,
  output logic            ready,
  output logic            in_reset,
  output logic            pmmr_clr,
  output logic            mcell_clr,
  output logic            gen_clr,
  output logic            vm_load,
  output logic [VM_W-1:0] vm_init,
  output logic            flash_abort,
  output logic            wr_go,
  output logic            pd_mode
);

  function automatic longint to_cyc(longint ns);
    longint c;
    c = (CLK_HZ * ns + 64'd999_999_999) / 64'd1_000_000_000;
    return (c < 2) ? 2 : c;
  endfunction

  localparam int POR_CYC   = int'(to_cyc(POR_NS));
  localparam int WARM_CYC  = int'(to_cyc(WARM_NS));
  localparam int REC_CYC   = int'(to_cyc(REC_NS));
  localparam int ABORT_CYC = int'(to_cyc(ABORT_NS));
  localparam int CW = $clog2((POR_CYC > WARM_CYC ? POR_CYC : WARM_CYC) + 1);
  localparam int RW = $clog2(REC_CYC + 1);
  localparam int AW = $clog2(ABORT_CYC + 1);

  typedef enum logic [2:0] {S_PWR, S_LOW, S_ARMED, S_REC, S_RUN} st_t;

  st_t           st;
  logic [1:0]    sync;
  logic          cold, qual, qcold, from_run, from_rec;
  logic [CW-1:0] cnt;
  logic [RW-1:0] rcnt;
  logic [AW-1:0] acnt;

  wire           pin_s  = sync[1];
  wire [CW-1:0]  need   = cold ? CW'(POR_CYC) : CW'(WARM_CYC);
  wire [CW-1:0]  cnt_nx = cnt + 1'b1;
  wire           rec_done = (rcnt >= RW'(REC_CYC - 1)) && (acnt == '0);

  always_ff @(posedge clk or negedge supply_good) begin
    if (!supply_good) sync <= 2'b11;
    else              sync <= {sync[0], rst_pin_n};
  end

  always_ff @(posedge clk or negedge supply_good) begin
    if (!supply_good) begin
      st       <= S_PWR;
      cold     <= 1'b1;
      qual     <= 1'b0;
      qcold    <= 1'b0;
      from_run <= 1'b0;
      from_rec <= 1'b0;
      cnt      <= '0;
      rcnt     <= '0;
      acnt     <= '0;
    end else begin
      qual <= 1'b0;
      if (acnt != '0) acnt <= acnt - 1'b1;
      case (st)
        S_PWR: if (!pin_s) begin
          st <= S_LOW; cnt <= CW'(1); from_run <= 1'b0; from_rec <= 1'b0;
        end
        S_RUN: if (!pin_s) begin
          st <= S_LOW; cnt <= CW'(1); from_run <= 1'b1; from_rec <= 1'b0;
        end
        S_REC: begin
          if (!pin_s) begin
            st <= S_LOW; cnt <= CW'(1); from_run <= 1'b0; from_rec <= 1'b1;
          end else if (rec_done) begin
            st <= S_RUN;
          end else if (rcnt < RW'(REC_CYC - 1)) begin
            rcnt <= rcnt + 1'b1;
          end
        end
        S_LOW: begin
          if (!pin_s) begin
            cnt <= cnt_nx;
            if (cnt_nx == need) begin
              st    <= S_ARMED;
              qual  <= 1'b1;
              qcold <= cold;
              cold  <= 1'b0;
              if (flash_busy) acnt <= AW'(ABORT_CYC);
            end
          end else begin
            rcnt <= '0;
            if (from_rec)      st <= S_REC;
            else if (from_run) st <= S_RUN;
            else               st <= S_PWR;
          end
        end
        S_ARMED: if (pin_s) begin
          st <= S_REC; rcnt <= '0;
        end
        default: st <= S_PWR;
      endcase
    end
  end

  assign ready       = (st == S_RUN) || (st == S_LOW && from_run);
  assign in_reset    = !ready;
  assign gen_clr     = qual;
  assign vm_load     = qual;
  assign pmmr_clr    = qual & qcold;
  assign mcell_clr   = qual & qcold;
  assign vm_init     = VM_DEFAULT & ~VM_ZERO_MASK;
  assign flash_abort = (acnt != '0);
  assign wr_go       = wr_req & ready & !supply_low;
  assign pd_mode     = pd_req & ready;

  assert_strobe_in_reset_R6: assert property (@(posedge clk) disable iff (!supply_good)
    gen_clr |-> in_reset);
  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!supply_good)
    gen_clr |=> !gen_clr);
  assert_abort_blocks_ready_R8: assert property (@(posedge clk) disable iff (!supply_good)
    flash_abort |-> !ready);
  assert_ready_from_recovery_R6: assert property (@(posedge clk) disable iff (!supply_good)
    $rose(ready) |-> $past(st == S_REC));
  assert_cold_strobe_once_R5: assert property (@(posedge clk) disable iff (!supply_good)
    pmmr_clr |=> !pmmr_clr && !mcell_clr);
  assert_no_strobe_while_ready_R3: assert property (@(posedge clk) disable iff (!supply_good)
    ready |-> !gen_clr && !vm_load);

endmodule

// File: tb/sim_rst_seq_mgr.sv
`timescale 1ns/1ps
module sim_rst_seq_mgr;
  localparam int CLK_PERIOD = 50;
  localparam int B_POR   = 20000;
  localparam int B_WARM  = 3;
  localparam int B_REC   = 3;
  localparam int B_ABORT = 500;

  logic clk = 0, supply_good = 0, rst_pin_n = 1, supply_low = 0;
  logic pd_req = 0, flash_busy = 0, wr_req = 0;
  logic ready, in_reset, pmmr_clr, mcell_clr, gen_clr, vm_load, flash_abort, wr_go, pd_mode;
  logic [7:0] vm_init;

  rst_seq_mgr u0 (.clk(clk), .supply_good(supply_good), .rst_pin_n(rst_pin_n),
    .supply_low(supply_low), .pd_req(pd_req), .flash_busy(flash_busy), .wr_req(wr_req),
    .ready(ready), .in_reset(in_reset), .pmmr_clr(pmmr_clr), .mcell_clr(mcell_clr),
    .gen_clr(gen_clr), .vm_load(vm_load), .vm_init(vm_init), .flash_abort(flash_abort),
    .wr_go(wr_go), .pd_mode(pd_mode));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int n_gen = 0, n_vm = 0, n_pmmr = 0, n_mc = 0, n_abort = 0;
  bit saw_low = 0, abort_ready = 0;

  always @(negedge clk) begin
    if (gen_clr) n_gen++;
    if (vm_load) n_vm++;
    if (pmmr_clr) n_pmmr++;
    if (mcell_clr) n_mc++;
    if (flash_abort) n_abort++;
    if (flash_abort && ready) abort_ready = 1;
    if (!ready) saw_low = 1;
  end

  localparam int VEC [5][3] = '{
    '{1, 0, 0}, '{B_WARM-1, 0, 0}, '{B_WARM, 1, 1}, '{B_WARM+1, 1, 1}, '{4*B_WARM, 1, 1}};

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(int w);
    @(negedge clk) rst_pin_n = 0;
    repeat (w) @(negedge clk);
    rst_pin_n = 1;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 5000) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n, g0, p0;
    repeat (4) @(negedge clk);
    chk(in_reset == 1 && ready == 0, "R1 reset state ready", ready, 0);
    chk(n_gen == 0 && n_abort == 0, "R1 no strobe in reset", n_gen, 0);
    supply_good = 1;
    repeat (4) @(negedge clk);

    pulse(B_POR - 1);
    repeat (20) @(negedge clk);
    chk(n_gen == 0, "R2 short power-on pulse ignored", n_gen, 0);
    chk(ready == 0, "R2 not ready after short pulse", ready, 0);

    @(negedge clk) rst_pin_n = 0;
    repeat (B_POR + 4) @(negedge clk);
    chk(in_reset == 1, "R6 in_reset during accepted reset", in_reset, 1);
    chk(n_gen == 1 && n_vm == 1, "R4 one clear and load strobe", n_gen, 1);
    chk(n_pmmr == 1 && n_mc == 1, "R5 cold-only strobes on power-on", n_pmmr, 1);
    chk(vm_init == 8'hA0, "R4 vm_init value", vm_init, 8'hA0);
    rst_pin_n = 1;
    wait_ready(n);
    chk(n == B_REC + 3, "R6 recovery delay", n, B_REC + 3);

    for (int i = 0; i < 5; i++) begin
      repeat (5) @(negedge clk);
      g0 = n_gen; p0 = n_pmmr; saw_low = 0;
      pulse(VEC[i][0]);
      repeat (40) @(negedge clk);
      chk(n_gen - g0 == VEC[i][1], "R3 warm pulse strobe count", n_gen - g0, VEC[i][1]);
      chk(int'(saw_low) == VEC[i][2], "R3 ready drop on warm pulse", saw_low, VEC[i][2]);
      chk(n_pmmr == p0, "R5 no page-map clear on warm", n_pmmr - p0, 0);
      chk(ready == 1, "R3 ready after vector", ready, 1);
    end

    pulse(5);
    @(negedge clk) rst_pin_n = 0;
    @(negedge clk) rst_pin_n = 1;
    wait_ready(n);
    chk(n + 2 == B_REC + 5, "R7 recovery restart", n + 2, B_REC + 5);

    repeat (5) @(negedge clk);
    n_abort = 0; abort_ready = 0;
    flash_busy = 1;
    pulse(5);
    flash_busy = 0;
    wait_ready(n);
    chk(n_abort == B_ABORT, "R8 abort length", n_abort, B_ABORT);
    chk(abort_ready == 0, "R8 ready held during abort", abort_ready, 0);
    chk(n > B_ABORT - 10 && ready, "R8 ready after abort", n, B_ABORT);
    n_abort = 0;
    pulse(5);
    wait_ready(n);
    chk(n_abort == 0, "R8 no abort when idle", n_abort, 0);

    @(negedge clk) wr_req = 1; supply_low = 1;
    @(negedge clk) chk(wr_go == 0, "R9 lockout blocks write", wr_go, 0);
    supply_low = 0;
    @(negedge clk) chk(wr_go == 1, "R9 write passes", wr_go, 1);
    rst_pin_n = 0;
    repeat (8) @(negedge clk);
    chk(wr_go == 0, "R9 write blocked in reset", wr_go, 0);
    rst_pin_n = 1; wr_req = 0;
    wait_ready(n);

    g0 = n_gen; saw_low = 0;
    @(negedge clk) pd_req = 1;
    @(negedge clk) chk(pd_mode == 1, "R10 pd_mode", pd_mode, 1);
    repeat (10) @(negedge clk);
    chk(n_gen == g0 && !saw_low, "R10 power-down no strobe", n_gen - g0, 0);
    pd_req = 0;
    @(negedge clk) chk(pd_mode == 0, "R10 pd_mode released", pd_mode, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule